// File: doc/BRIEF.md
# Mask-Partitioned Packed SIMD Adder

This block is a 32-bit integer adder whose carry chain can be cut at any bit position. A partition mask register decides where the cuts go. In packed mode, every set mask bit stops the carry from entering that bit. That bit then becomes the lowest bit of a new, independent element. Elements can have any width and need not be equal, so formats such as two RGB565 pixels per word add field by field in a single operation.

In plain mode the mask has no effect and the block is an ordinary 32-bit adder. The mask is held in a register that has a synchronous write port and resets to zero. The sum is formed combinationally from the operands, the mask and the mode. A parameter can add an output register stage after it, and that stage is present by default.

The block has no sequencer, so its behaviour is set by two pieces of state. The mode input has two named values: `ADD_WHOLE` (0) selects the plain add and `ADD_SPLIT` (1) selects the packed add. The mask register has two transitions. A load takes place on a clock edge while `mask_we` is high. A hold takes place on every other edge. Reset forces the mask to all zeros.

Top module: `part_simd_adder`

## Requirements
- R1: With `packed_mode` = 0 (`ADD_WHOLE`), `sum` is `op_a + op_b` modulo 2^32, and carry ripples across all 32 bits whatever the mask holds.
- R2: With `packed_mode` = 1 (`ADD_SPLIT`), a set mask bit i (1 ≤ i ≤ 31) blocks the carry into bit i, and bit i starts a new element.
- R3: In packed mode, each element of `sum` equals the sum of the matching fields of `op_a` and `op_b` modulo 2^width of that element. The carry out of the element's top bit is dropped.
- R4: Mask bit 0 never changes the result.
- R5: A packed add with an all-zero mask gives the same result as a plain add.
- R6: A packed add with an all-ones mask gives `op_a ^ op_b`.
- R7: The mask register resets to zero. It takes `mask_wdata` on a rising clock edge while `mask_we` is 1, and it holds its value otherwise. A written mask applies to operands presented from the next cycle on.
- R8: With the default `OUT_REG` = 1, `sum` is registered. It is zero during reset and shows the result of the inputs sampled at one rising edge after that edge, holding the value until the next edge.
- R9: The RGB565 pair mask 0x0821_0820 (bits 5, 11, 16, 21, 27) splits the word into six independent fields: 4..0, 10..5, 15..11, 20..16, 26..21 and 31..27.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mask_we | input | 1 | Write enable for the partition mask register |
| mask_wdata | input | 32 | New partition mask value |
| packed_mode | input | 1 | 0 selects the plain add, 1 selects the packed add |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| sum | output | 32 | Result (registered when OUT_REG = 1) |

## Verification
A wrong mask bit or a broken kill gate shows as a result that differs from the expected value in exactly the bits above a false or missing element boundary. It appears on the first add whose operands carry across that boundary, one cycle after the inputs are taken. A mask register that misses or invents a load corrupts the very next packed add. Because of this, the stimulus includes carry-heavy all-ones operands, which expose every boundary at once, and random masks, which move the boundaries to every position.

// File: rtl/psa_pkg.sv
package psa_pkg;
    typedef enum logic {
        ADD_WHOLE = 1'b0,
        ADD_SPLIT = 1'b1
    } add_mode_e;
endpackage

// File: rtl/psa_mask_reg.sv
module psa_mask_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] mask
);
    logic live_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask   <= '0;
            live_q <= 1'b0;
        end else begin
            live_q <= 1'b1;
            if (wr_en) begin
                mask <= wr_data;
            end
        end
    end

    // R7
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && $past(wr_en) |-> mask == $past(wr_data));

    // R7
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && !$past(wr_en) |-> $stable(mask));
endmodule

// File: rtl/psa_split_chain.sv
module psa_split_chain #(
    parameter int W = 32
) (
    input  psa_pkg::add_mode_e mode,
    input  logic [W-1:0]       a,
    input  logic [W-1:0]       b,
    input  logic [W-1:0]       mask,
    output logic [W-1:0]       s
);
    import psa_pkg::*;

    logic [W-1:0] kill;
    logic [W:0]   carry;
    logic [W-1:0] cin_eff;

    always_comb begin
        unique case (mode)
            ADD_WHOLE: kill = '0;
            ADD_SPLIT: kill = mask;
            default:   kill = '0;
        endcase
    end

    assign carry[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign cin_eff[i]  = carry[i] & ~kill[i];
        assign s[i]        = a[i] ^ b[i] ^ cin_eff[i];
        assign carry[i+1]  = (a[i] & b[i]) | (cin_eff[i] & (a[i] ^ b[i]));
    end
endmodule

// File: rtl/psa_out_stage.sv
module psa_out_stage #(
    parameter int W   = 32,
    parameter bit REG = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    if (REG) begin : g_reg
        logic live_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q      <= '0;
                live_q <= 1'b0;
            end else begin
                q      <= d;
                live_q <= 1'b1;
            end
        end

        // R8
        out_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
            live_q |-> q == $past(d));
    end else begin : g_comb
        logic unused_ok;
        assign unused_ok = clk ^ rst_n;
        assign q = d;
    end
endmodule

// File: rtl/part_simd_adder.sv
module part_simd_adder #(
    parameter int W       = 32,
    parameter bit OUT_REG = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mask_we,
    input  logic [31:0]  mask_wdata,
    input  logic         packed_mode,
    input  logic [31:0]  op_a,
    input  logic [31:0]  op_b,
    output logic [31:0]  sum
);
    import psa_pkg::*;

    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    add_mode_e    mode;
    logic [W-1:0] mask_q;
    logic [W-1:0] raw_sum;

    assign mode = add_mode_e'(packed_mode);

    psa_mask_reg #(.W(W)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mask_we),
        .wr_data (mask_wdata),
        .mask    (mask_q)
    );

    psa_split_chain #(.W(W)) u_chain (
        .mode (mode),
        .a    (op_a),
        .b    (op_b),
        .mask (mask_q),
        .s    (raw_sum)
    );

    // R1
    plain_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode == ADD_WHOLE |-> raw_sum == W'(op_a + op_b));

    // R5
    zero_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == ADD_SPLIT && mask_q == '0) |-> raw_sum == W'(op_a + op_b));

    // R6
    full_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == ADD_SPLIT && mask_q == ALL_ONES) |-> raw_sum == (op_a ^ op_b));

    // R2
    lsb_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == ADD_SPLIT && mask_q[1]) |-> raw_sum[0] == (op_a[0] ^ op_b[0]));

    psa_out_stage #(.W(W), .REG(OUT_REG)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_sum),
        .q     (sum)
    );
endmodule

// File: tb/tb_part_simd_adder.sv
module tb_part_simd_adder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mask_we = 1'b0;
    logic [31:0] mask_wdata = '0;
    logic        packed_mode = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [31:0] sum;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    part_simd_adder dut (
        .clk(clk), .rst_n(rst_n), .mask_we(mask_we), .mask_wdata(mask_wdata),
        .packed_mode(packed_mode), .op_a(op_a), .op_b(op_b), .sum(sum)
    );

    typedef struct packed {
        logic        md;
        logic [31:0] m;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 32'h0821_0820, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000}, // R1
        '{1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFE}, // R1
        '{1'b0, 32'h0001_0000, 32'h0000_FFFF, 32'h0000_0001, 32'h0001_0000}, // R1
        '{1'b1, 32'h0001_0000, 32'h0000_FFFF, 32'h0000_0001, 32'h0000_0000}, // R2
        '{1'b1, 32'h8000_0000, 32'h7FFF_FFFF, 32'h0000_0001, 32'h0000_0000}, // R2
        '{1'b1, 32'h0001_0000, 32'h1234_FFFF, 32'h1111_0002, 32'h2345_0001}, // R3
        '{1'b1, 32'h0000_0001, 32'h0000_0001, 32'h0000_0001, 32'h0000_0002}, // R4
        '{1'b1, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000}, // R5
        '{1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0001, 32'hFFFF_FFFE}, // R6
        '{1'b1, 32'hFFFF_FFFF, 32'hA5A5_0F0F, 32'h5A5A_FF00, 32'hFFFF_F00F}, // R6
        '{1'b1, 32'h0821_0820, 32'hFFFF_FFFF, 32'h0000_0001, 32'hFFFF_FFE0}, // R9
        '{1'b1, 32'h0821_0820, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hF7DE_F7DE}  // R9
    };

    function automatic logic [31:0] ref_add(logic md, logic [31:0] m,
                                            logic [31:0] a, logic [31:0] b);
        logic [31:0] r = '0;
        int lo = 0;
        for (int i = 1; i <= 32; i++) begin
            if (i == 32 || (md && m[i])) begin
                logic [63:0] fm = (64'd1 << (i - lo)) - 64'd1;
                logic [63:0] fs = ((({32'd0, a}) >> lo) & fm) + ((({32'd0, b}) >> lo) & fm);
                r  = r | 32'((fs & fm) << lo);
                lo = i;
            end
        end
        return r;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: sum=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(logic md, logic [31:0] m, logic [31:0] a, logic [31:0] b);
        @(negedge clk);
        mask_we = 1'b1; mask_wdata = m;
        @(negedge clk);
        mask_we = 1'b0; mask_wdata = ~m;
        packed_mode = md; op_a = a; op_b = b;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        packed_mode = 1'b1; op_a = 32'hFFFF_FFFF; op_b = 32'h1;
        repeat (3) @(negedge clk);
        check("R8 reset value", sum, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        // R7: mask starts at zero after reset, so the packed add is a full add
        check("R7 reset mask", sum, 32'h0);

        for (int k = 0; k < NV; k++) begin
            apply(VECS[k].md, VECS[k].m, VECS[k].a, VECS[k].b);
            check("table R1-9", sum, VECS[k].exp);
            check("table ref", sum, ref_add(VECS[k].md, VECS[k].m, VECS[k].a, VECS[k].b));
        end

        // R7: with write enable low the mask holds, while wdata shows the inverse
        apply(1'b1, 32'h0821_0820, 32'h0, 32'h0);
        mask_wdata = 32'h0;
        op_a = 32'hFFFF_FFFF; op_b = 32'hFFFF_FFFF;
        @(negedge clk);
        @(negedge clk);
        check("R7 hold", sum, 32'hF7DE_F7DE);

        // R8: new inputs do not show before the next rising edge
        op_a = 32'h1; op_b = 32'h1; packed_mode = 1'b0;
        #1;
        check("R8 latency hold", sum, 32'hF7DE_F7DE);
        @(negedge clk);
        check("R8 latency update", sum, 32'h2);

        // R4: toggling mask bit 0 leaves the packed result unchanged
        for (int k = 0; k < 20; k++) begin
            logic [31:0] m = $urandom;
            logic [31:0] a = $urandom;
            logic [31:0] b = $urandom;
            logic [31:0] r0;
            apply(1'b1, m & 32'hFFFF_FFFE, a, b);
            r0 = sum;
            apply(1'b1, m | 32'h1, a, b);
            check("R4 bit0", sum, r0);
        end

        // R2 R3: random masks and operands, including carry-heavy values
        for (int k = 0; k < 300; k++) begin
            logic        md = 1'($urandom);
            logic [31:0] m = $urandom;
            logic [31:0] a = (k % 4 == 0) ? 32'hFFFF_FFFF : $urandom;
            logic [31:0] b = (k % 3 == 0) ? 32'hFFFF_FFFF : $urandom;
            if (k % 5 == 0) m = m & $urandom & $urandom;
            apply(md, m, a, b);
            check(md ? "R3 random packed" : "R1 random plain", sum, ref_add(md, m, a, b));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule